// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block sits between a requester that wants to move one operand (a byte, a word or a long word) and an asynchronous external bus. It accepts a request and runs as many bus cycles as the addressed slave needs. On each cycle the slave reports its port width through a two-bit active-low acknowledge code. The controller moves as many bytes as that width allows, then runs follow-on cycles until the whole operand has moved.

The operand is handled in big-endian byte order: its most significant byte moves first. On every cycle the bus carries the next unmoved bytes on its upper lanes, starting at bits 31:24. Read pieces are placed into an operand register and returned right-justified once the operand is complete. A bus error ends the transfer with an error status. A bus error together with halt ends it with a retry status, and the requester may reissue the request later. Operands are assumed to be aligned to their own size.

Top module: `dbs_ctrl`

## Requirements
- R1: While and after reset, `bus_strobe`, `busy_o`, `done_o`, `err_o` and `retry_o` are low until a request is accepted.
- R2: A request is taken on a rising edge when `req_valid` is high and `busy_o` is low. From the next cycle, `bus_strobe` is high, `bus_addr` equals `req_addr` and `bus_len` gives the operand byte count. `req_size` is encoded as 00 = byte (1), 01 = word (2), and 10 or 11 = long word (4).
- R3: With `ack_n` = 11 and `berr_n` high, the bus cycle is stretched: `bus_strobe`, `bus_addr` and `bus_len` hold. The codes 10, 01 and 00 end the cycle with an 8-, 16- or 32-bit port respectively.
- R4: An acknowledged cycle moves min(port bytes, `bus_len`) bytes. If bytes remain, `bus_strobe` is low for exactly one cycle. The next cycle then starts with `bus_addr` advanced by the bytes moved so far and `bus_len` lowered by the same amount.
- R5: A long word takes one cycle on a 32-bit port, two on a 16-bit port and four on an 8-bit port.
- R6: The port width is taken afresh on every bus cycle, so one operand may move through a mix of widths.
- R7: On a read, the valid bytes of each piece are taken from the upper lanes of `bus_rdata`, and all other lanes are ignored. When `done_o` is high, `rdata_o` holds the operand right-justified, with the unused upper bits at zero.
- R8: On a write, while `bus_strobe` is high, the upper lanes of `bus_wdata` carry the operand's next unsent bytes, most significant first.
- R9: After the final acknowledge edge, `done_o` is high for one cycle, while `bus_strobe` and `busy_o` are low.
- R10: `berr_n` low with `halt_n` high during a strobed cycle abandons the transfer. `err_o` then pulses for one cycle and `done_o` stays low.
- R11: `berr_n` and `halt_n` both low during a strobed cycle abandon the transfer. `retry_o` then pulses for one cycle, and both `err_o` and `done_o` stay low.
- R12: At most one of `done_o`, `err_o` and `retry_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Operand address |
| req_wdata | input | 32 | Write operand, right-justified |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer completed (pulse) |
| err_o | output | 1 | Transfer ended by bus error (pulse) |
| retry_o | output | 1 | Transfer ended by retry (pulse) |
| rdata_o | output | 32 | Read operand, right-justified |
| bus_strobe | output | 1 | Bus cycle active |
| bus_write | output | 1 | Direction of the current cycle |
| bus_addr | output | ADDR_W | Address of the current cycle |
| bus_len | output | 3 | Bytes still to move (1 to 4) |
| bus_wdata | output | 32 | Write data, next bytes on upper lanes |
| bus_rdata | input | 32 | Read data from the slave |
| ack_n | input | 2 | Active-low port-size acknowledge |
| berr_n | input | 1 | Active-low bus error |
| halt_n | input | 1 | Active-low halt |

## Verification
Every result appears one register stage after the edge that causes it. The strobe rises in the cycle after acceptance. The status pulses, the updated address and the strobe's fall all appear in the cycle after the edge that samples the terminating code. The follow-on strobe returns one cycle later still. The bench drives inputs on falling edges and reads outputs on the following falling edge, so each check lands in the cycle where its result is due. At that point it checks address, length and write lanes against a byte count it tracks itself, and after the last piece it checks the status pulse and the read result.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP
    } seq_state_e;

    typedef enum logic [1:0] {
        TM_WAIT,
        TM_ACK,
        TM_ERR,
        TM_RETRY
    } term_kind_e;

    typedef struct packed {
        term_kind_e kind;
        logic [2:0] port_bytes;
    } term_t;

    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] min_bytes(input logic [2:0] a, input logic [2:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode
    import dbs_pkg::*;
(
    input  logic [1:0] ack_n,
    input  logic       berr_n,
    input  logic       halt_n,
    output term_t      term
);

    always_comb begin
        term.port_bytes = 3'd0;
        term.kind       = TM_WAIT;
        if (!berr_n) begin
            term.kind = halt_n ? TM_ERR : TM_RETRY;
        end else begin
            case (ack_n)
                2'b10: begin term.kind = TM_ACK; term.port_bytes = 3'd1; end
                2'b01: begin term.kind = TM_ACK; term.port_bytes = 3'd2; end
                2'b00: begin term.kind = TM_ACK; term.port_bytes = 3'd4; end
                default: term.kind = TM_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer
    import dbs_pkg::*;
(
    input  logic [DATA_W-1:0] opbuf,
    input  logic [2:0]        moved,
    input  logic [2:0]        take,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] wdata
);

    // Write lanes: unsent bytes slide up to the top of the bus.
    assign wdata = opbuf << {moved, 3'b000};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic       hit;
        logic [7:0] pick;
        logic [7:0] lane_out;
        int         src;

        always_comb begin
            src      = (g - int'(moved)) & (LANES - 1);
            hit      = (g >= int'(moved)) && (g < int'(moved) + int'(take));
            pick     = bus_rdata[DATA_W-1-8*src -: 8];
            lane_out = hit ? pick : opbuf[DATA_W-1-8*g -: 8];
        end

        assign merged[DATA_W-1-8*g -: 8] = lane_out;
    end

endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  term_t             term,
    input  logic [DATA_W-1:0] merged,
    output logic              busy_o,
    output logic              strobe,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_len,
    output logic [2:0]        moved,
    output logic [2:0]        take,
    output logic [DATA_W-1:0] opbuf,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              err_o,
    output logic              retry_o
);

    seq_state_e state;
    logic [2:0] total;
    logic       last_piece;
    logic [2:0] req_bytes;

    always_comb begin
        bus_len    = total - moved;
        take       = min_bytes(term.port_bytes, bus_len);
        last_piece = (3'(moved + take) == total);
        req_bytes  = size_to_bytes(req_size);
        strobe     = (state == ST_RUN);
        busy_o     = (state != ST_IDLE);
        rdata_o    = opbuf >> {3'(3'd4 - total), 3'b000};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            total     <= 3'd0;
            moved     <= 3'd0;
            bus_addr  <= '0;
            bus_write <= 1'b0;
            opbuf     <= '0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
            retry_o   <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            retry_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_RUN;
                        bus_addr  <= req_addr;
                        total     <= req_bytes;
                        moved     <= 3'd0;
                        bus_write <= req_write;
                        opbuf     <= req_write ?
                                     (req_wdata << {3'(3'd4 - req_bytes), 3'b000}) : '0;
                    end
                end
                ST_RUN: begin
                    case (term.kind)
                        TM_ACK: begin
                            if (!bus_write) opbuf <= merged;
                            moved    <= 3'(moved + take);
                            bus_addr <= bus_addr + ADDR_W'(take);
                            if (last_piece) begin
                                state  <= ST_IDLE;
                                done_o <= 1'b1;
                            end else begin
                                state <= ST_GAP;
                            end
                        end
                        TM_ERR: begin
                            state <= ST_IDLE;
                            err_o <= 1'b1;
                        end
                        TM_RETRY: begin
                            state   <= ST_IDLE;
                            retry_o <= 1'b1;
                        end
                        default: state <= ST_RUN;
                    endcase
                end
                ST_GAP:  state <= ST_RUN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (bus_len >= 3'd1 && bus_len <= 3'd4));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && term.kind == TM_WAIT) |=> (strobe && $stable(bus_addr) && $stable(bus_len)));

    // R4
    addr_len_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && term.kind == TM_ACK && bus_len > take) |=>
        ((bus_addr + ADDR_W'(bus_len)) == $past(bus_addr + ADDR_W'(bus_len))));

    // R4
    gap_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && term.kind == TM_ACK && bus_len > take) |=> (!strobe ##1 strobe));

    // R10
    err_end_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && term.kind == TM_ERR) |=> (err_o && !strobe && !done_o));

    // R12
    status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o, retry_o}));

endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              retry_o,
    output logic [31:0]       rdata_o,
    output logic              bus_strobe,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_len,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic [1:0]        ack_n,
    input  logic              berr_n,
    input  logic              halt_n
);

    term_t             term;
    logic [2:0]        moved;
    logic [2:0]        take;
    logic [DATA_W-1:0] opbuf;
    logic [DATA_W-1:0] merged;

    dbs_ack_decode u_dec (
        .ack_n  (ack_n),
        .berr_n (berr_n),
        .halt_n (halt_n),
        .term   (term)
    );

    dbs_lane_steer u_lanes (
        .opbuf     (opbuf),
        .moved     (moved),
        .take      (take),
        .bus_rdata (bus_rdata),
        .merged    (merged),
        .wdata     (bus_wdata)
    );

    dbs_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .term      (term),
        .merged    (merged),
        .busy_o    (busy_o),
        .strobe    (bus_strobe),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_len   (bus_len),
        .moved     (moved),
        .take      (take),
        .opbuf     (opbuf),
        .rdata_o   (rdata_o),
        .done_o    (done_o),
        .err_o     (err_o),
        .retry_o   (retry_o)
    );

    // R11
    retry_not_err_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && !berr_n && !halt_n) |=> (retry_o && !err_o && !done_o));

endmodule

// File: tb/dbs_ctrl_tb.sv
module dbs_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata;
    logic        busy_o, done_o, err_o, retry_o;
    logic [31:0] rdata_o;
    logic        bus_strobe, bus_write;
    logic [31:0] bus_addr;
    logic [2:0]  bus_len;
    logic [31:0] bus_wdata, bus_rdata;
    logic [1:0]  ack_n;
    logic        berr_n, halt_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dbs_ctrl #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .retry_o(retry_o),
        .rdata_o(rdata_o),
        .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int size_bytes(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [1:0] ack_code(input int port);
        return (port == 1) ? 2'b10 : (port == 2) ? 2'b01 : 2'b00;
    endfunction

    function automatic int pick_port();
        int r;
        r = int'($urandom_range(0, 2));
        return (r == 0) ? 1 : (r == 1) ? 2 : 4;
    endfunction

    // fixed_port = 0 picks a width per cycle; fail_at < 0 means no error cycle.
    task automatic xfer(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] raw, input int fixed_port, input int maxwait,
                        input int fail_at, input bit fail_halt, input string tag);
        int nb, m, k, w, port, take;
        bit fin;
        logic [31:0] val, vleft;
        nb    = size_bytes(sz);
        val   = (nb == 4) ? raw : (raw & ((32'h1 << (8 * nb)) - 32'h1));
        vleft = val << (8 * (4 - nb));
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr;
        req_wdata = wr ? raw : $urandom;
        @(negedge clk);
        req_valid = 1'b0;
        m = 0; k = 0; fin = 1'b0;
        while (!fin) begin
            chk(bus_strobe && bus_addr == addr + 32'(m) && int'(bus_len) == nb - m,
                (k == 0) ? "R2 start" : "R4 follow-on", bus_addr, addr + 32'(m));
            w = (maxwait > 0) ? int'($urandom_range(0, maxwait)) : 0;
            for (int i = 0; i < w; i++) begin
                @(negedge clk);
                chk(bus_strobe && bus_addr == addr + 32'(m) && int'(bus_len) == nb - m,
                    "R3 wait hold", {29'd0, bus_len}, 32'(nb - m));
            end
            if (k == fail_at) begin
                berr_n = 1'b0; halt_n = !fail_halt;
                @(negedge clk);
                berr_n = 1'b1; halt_n = 1'b1;
                if (fail_halt)
                    chk(retry_o && !err_o && !done_o && !bus_strobe && !busy_o, "R11 retry",
                        {done_o, err_o, retry_o}, 32'd1);
                else
                    chk(err_o && !retry_o && !done_o && !bus_strobe && !busy_o, "R10 error",
                        {done_o, err_o, retry_o}, 32'd2);
                @(negedge clk);
                chk(!err_o && !retry_o && !done_o, "R12 status pulse ends",
                    {done_o, err_o, retry_o}, 32'd0);
                return;
            end
            port = (fixed_port != 0) ? fixed_port : pick_port();
            take = (port < nb - m) ? port : nb - m;
            for (int j = 0; j < 4; j++)
                bus_rdata[31 - 8 * j -: 8] = (j < take) ? vleft[31 - 8 * (m + j) -: 8] : 8'($urandom);
            if (wr)
                for (int j = 0; j < take; j++)
                    chk(bus_wdata[31 - 8 * j -: 8] == vleft[31 - 8 * (m + j) -: 8] && bus_write,
                        "R8 write lane", {24'd0, bus_wdata[31 - 8 * j -: 8]},
                        {24'd0, vleft[31 - 8 * (m + j) -: 8]});
            ack_n = ack_code(port);
            @(negedge clk);
            ack_n = 2'b11;
            bus_rdata = $urandom;
            m += take; k++;
            if (m == nb) begin
                chk(done_o && !err_o && !retry_o && !bus_strobe && !busy_o, "R9 done",
                    {done_o, err_o, retry_o}, 32'd4);
                if (!wr) chk(rdata_o == val, (fixed_port == 0) ? "R6/R7 read" : "R7 read", rdata_o, val);
                if (fixed_port != 0)
                    chk(k == (nb + fixed_port - 1) / fixed_port, "R5 cycle count", 32'(k),
                        32'((nb + fixed_port - 1) / fixed_port));
                @(negedge clk);
                chk(!done_o, "R9 single pulse", {31'd0, done_o}, 32'd0);
                fin = 1'b1;
            end else begin
                chk(!bus_strobe && !done_o && busy_o, "R4 gap", {31'd0, bus_strobe}, 32'd0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
        req_addr = '0; req_wdata = '0; bus_rdata = '0;
        ack_n = 2'b11; berr_n = 1'b1; halt_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_strobe && !busy_o && !done_o && !err_o && !retry_o, "R1 in reset",
            {bus_strobe, busy_o, done_o, err_o, retry_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_strobe && !busy_o && !done_o && !err_o && !retry_o, "R1 after reset",
            {bus_strobe, busy_o, done_o, err_o, retry_o}, 32'd0);

        // Directed corner cases
        xfer(1'b0, 2'b10, 32'h0000_1000, 32'hA1B2_C3D4, 4, 0, -1, 1'b0, "R5");
        xfer(1'b0, 2'b10, 32'h0000_2000, 32'h1122_3344, 2, 0, -1, 1'b0, "R5");
        xfer(1'b0, 2'b11, 32'h0000_3000, 32'h5566_7788, 1, 0, -1, 1'b0, "R5");
        xfer(1'b0, 2'b01, 32'h0000_4002, 32'hFFFF_9ABC, 1, 0, -1, 1'b0, "R7");
        xfer(1'b0, 2'b00, 32'h0000_5003, 32'hDEAD_BE5A, 4, 0, -1, 1'b0, "R7");
        xfer(1'b1, 2'b10, 32'h0000_6000, 32'hCAFE_F00D, 1, 0, -1, 1'b0, "R8");
        xfer(1'b1, 2'b01, 32'h0000_7000, 32'h0000_1357, 2, 0, -1, 1'b0, "R8");
        xfer(1'b0, 2'b10, 32'h0000_8000, 32'h0BAD_F00D, 2, 4, -1, 1'b0, "R3");
        xfer(1'b0, 2'b10, 32'h0000_9000, 32'h1234_5678, 1, 0, 2, 1'b0, "R10");
        xfer(1'b1, 2'b10, 32'h0000_A000, 32'h8765_4321, 2, 0, 0, 1'b1, "R11");
        xfer(1'b0, 2'b10, 32'h0000_B000, 32'h2468_ACE0, 0, 2, -1, 1'b0, "R6");

        // Constrained random mix
        for (int t = 0; t < 300; t++) begin
            int fa;
            fa = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 3)) : -1;
            xfer(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 $urandom & 32'hFFFF_FFFC, $urandom, 0, 3, fa,
                 1'($urandom_range(0, 1)), "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule